// File: doc/BRIEF.md
# Bus Master Control and Error-Cause Register

This block is a 16-bit register that sets the operating mode of a bus-interface master and keeps a record of why the most recent bus error happened. The eleven low bits are control bits that software can read and write. The five high bits are status flags. Each status flag is active-low: it is driven to 0 when its error condition is observed. Any read of the register returns every status flag to 1, so software can read the cause of an error and re-arm the register in a single access.

A board without a processor can still configure the block. While reset is held, the control bits take their values from eleven strap inputs. The block decodes the control bits into plain mode outputs for the master, the requester and the transfer timer. The master-enable output also depends on an external slave-only input. The register port has no handshake: a chip select with a write strobe performs a write, a chip select without the write strobe performs a read, and the read data output always shows the current register contents.

Top module: `bicsr_top`

## Requirements
- R1: While rst_n is low, control bits 10:0 load from strap_i on each clock edge and all five status flags (bits 15:11) are set to 1.
- R2: When cs_i and we_i are both high at a clock edge, control bits 10:0 take wdata_i[10:0] after that edge. rdata_o always equals {status[15:11], control[10:0]}.
- R3: A write has no effect on bits 15:11. Those bits change only through error capture (R5 to R7) and read-set (R4).
- R4: When cs_i is high and we_i is low at a clock edge, every status bit becomes 1 after that edge, unless R8 applies to that bit.
- R5: Bit 11 (write error) is cleared when bus_wr_try_i is high while control bit 5 is 0 (read-only mode). When control bit 5 is 1, bus_wr_try_i has no effect on bit 11.
- R6: Bit 12 (timeout) is cleared after an edge at which tmo_expired_i is high.
- R7: At an edge where bus_err_n_i is low, bit 15 is cleared, bit 13 takes the level of ack0_n_i and bit 14 takes the level of ack1_n_i.
- R8: If an error capture and a read occur on the same edge, the captured values win for the bits that the capture affects.
- R9: master_en_o is 1 only when control bit 6 is 0 and slave_only_i is 0.
- R10: The remaining decodes are:
  - sysctl_en_o = !bit0
  - blk_xfer_o = !bit2
  - narrow_cpu_o = !bit3
  - bounce_en_o = bit4
  - rd_only_o = !bit5
  - fair_en_o = !bit10
  - tmo_sel_o = {bit9, bit8}
  - tmo_off_o = bit9 & bit8

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_i | input | 11 | Control values loaded during reset |
| cs_i | input | 1 | Register access select |
| we_i | input | 1 | Write strobe (1 = write, 0 = read) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Current register contents |
| bus_err_n_i | input | 1 | Bus error line, active low |
| ack0_n_i | input | 1 | Address/size acknowledge line 0 |
| ack1_n_i | input | 1 | Address/size acknowledge line 1 |
| tmo_expired_i | input | 1 | Transfer timer expired |
| bus_wr_try_i | input | 1 | Local logic attempts a bus write |
| slave_only_i | input | 1 | Board uses the slave side only |
| sysctl_en_o | output | 1 | Act as system controller |
| blk_xfer_o | output | 1 | Block-transfer mode requested |
| narrow_cpu_o | output | 1 | 24-bit-address processor mode |
| bounce_en_o | output | 1 | Address bounce enabled |
| rd_only_o | output | 1 | Read-only mode |
| master_en_o | output | 1 | Master enabled |
| tmo_sel_o | output | 2 | Transfer timer period select |
| tmo_off_o | output | 1 | Transfer timer disabled |
| fair_en_o | output | 1 | Fair request mode |

## Verification
The bench aims at three cases in particular. The first is a read that coincides with an error capture: a design that let the read-set win would lose the error cause. The second is a write with the high bits set: a design that stored them would fake or erase a status flag. The third is a bus write attempt while the read-only bit is 1: a design that ignored the mode bit would report false write errors. The bench also checks that the acknowledge lines are sampled only on the error edge, and that a second reset with a different strap pattern reloads the control bits. A design that kept stale control bits across that second reset would fail this check.

// File: rtl/bicsr_pkg.sv
package bicsr_pkg;
  localparam int CTRL_W = 11;
  localparam int STAT_W = 5;
  // control bit positions (decoded by neighbours, so fixed)
  localparam int B_SYSCTL = 0;
  localparam int B_BLK    = 2;
  localparam int B_NARROW = 3;
  localparam int B_BOUNCE = 4;
  localparam int B_RDONLY = 5;
  localparam int B_MSTDIS = 6;
  localparam int B_TMO0   = 8;
  localparam int B_TMO1   = 9;
  localparam int B_FAIR   = 10;
  // status flag index within the status field
  localparam int S_WRERR = 0;
  localparam int S_TMO   = 1;
  localparam int S_ACK0  = 2;
  localparam int S_ACK1  = 3;
  localparam int S_ERR   = 4;

  typedef struct packed {
    logic bus_err;
    logic ack1_n;
    logic ack0_n;
    logic tmo;
    logic wr_err;
  } evt_t;
endpackage

// File: rtl/bicsr_ctrl_reg.sv
module bicsr_ctrl_reg
  import bicsr_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] strap,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)     ctrl[i] <= strap[i];
      else if (wr_en) ctrl[i] <= wdata[i];
    end
  end
endmodule

// File: rtl/bicsr_status_cap.sv
module bicsr_status_cap
  import bicsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_set,
  input  evt_t              evt,
  output logic [STAT_W-1:0] stat
);
  logic [STAT_W-1:0] base, nxt;

  always_comb begin
    base = rd_set ? '1 : stat;
    nxt  = base;
    if (evt.wr_err)  nxt[S_WRERR] = 1'b0;
    if (evt.tmo)     nxt[S_TMO]   = 1'b0;
    if (evt.bus_err) begin
      nxt[S_ERR]  = 1'b0;
      nxt[S_ACK0] = evt.ack0_n;
      nxt[S_ACK1] = evt.ack1_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '1;
    else        stat <= nxt;
  end
endmodule

// File: rtl/bicsr_decode.sv
module bicsr_decode
  import bicsr_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              slave_only,
  output logic              sysctl_en,
  output logic              blk_xfer,
  output logic              narrow_cpu,
  output logic              bounce_en,
  output logic              rd_only,
  output logic              master_en,
  output logic [1:0]        tmo_sel,
  output logic              tmo_off,
  output logic              fair_en
);
  logic unused_spare;
  assign unused_spare = ^{ctrl[1], ctrl[7]};

  always_comb begin
    sysctl_en  = ~ctrl[B_SYSCTL];
    blk_xfer   = ~ctrl[B_BLK];
    narrow_cpu = ~ctrl[B_NARROW];
    bounce_en  =  ctrl[B_BOUNCE];
    rd_only    = ~ctrl[B_RDONLY];
    master_en  = ~ctrl[B_MSTDIS] & ~slave_only;
    tmo_sel    = {ctrl[B_TMO1], ctrl[B_TMO0]};
    tmo_off    = ctrl[B_TMO1] & ctrl[B_TMO0];
    fair_en    = ~ctrl[B_FAIR];
  end
endmodule

// File: rtl/bicsr_top.sv
module bicsr_top
  import bicsr_pkg::*;
#(
  parameter int DATA_W = CTRL_W + STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] strap_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              bus_err_n_i,
  input  logic              ack0_n_i,
  input  logic              ack1_n_i,
  input  logic              tmo_expired_i,
  input  logic              bus_wr_try_i,
  input  logic              slave_only_i,
  output logic              sysctl_en_o,
  output logic              blk_xfer_o,
  output logic              narrow_cpu_o,
  output logic              bounce_en_o,
  output logic              rd_only_o,
  output logic              master_en_o,
  output logic [1:0]        tmo_sel_o,
  output logic              tmo_off_o,
  output logic              fair_en_o
);
  localparam int HI_W = DATA_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl;
  logic [STAT_W-1:0] stat;
  logic              wr_en, rd_set;
  evt_t              evt;
  logic [HI_W-1:0]   unused_hi;

  assign unused_hi = wdata_i[DATA_W-1:CTRL_W];
  assign wr_en     = cs_i & we_i;
  assign rd_set    = cs_i & ~we_i;

  always_comb begin
    evt.wr_err  = bus_wr_try_i & ~ctrl[B_RDONLY];
    evt.tmo     = tmo_expired_i;
    evt.bus_err = ~bus_err_n_i;
    evt.ack0_n  = ack0_n_i;
    evt.ack1_n  = ack1_n_i;
  end

  bicsr_ctrl_reg #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strap(strap_i),
    .wr_en(wr_en), .wdata(wdata_i[CTRL_W-1:0]), .ctrl(ctrl)
  );

  bicsr_status_cap u_stat (
    .clk(clk), .rst_n(rst_n), .rd_set(rd_set), .evt(evt), .stat(stat)
  );

  bicsr_decode u_dec (
    .ctrl(ctrl), .slave_only(slave_only_i),
    .sysctl_en(sysctl_en_o), .blk_xfer(blk_xfer_o), .narrow_cpu(narrow_cpu_o),
    .bounce_en(bounce_en_o), .rd_only(rd_only_o), .master_en(master_en_o),
    .tmo_sel(tmo_sel_o), .tmo_off(tmo_off_o), .fair_en(fair_en_o)
  );

  assign rdata_o = {stat, ctrl};
endmodule

// File: rtl/bicsr_checker.sv
module bicsr_checker
  import bicsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_i,
  input logic              we_i,
  input logic [15:0]       wdata_i,
  input logic [15:0]       rdata_o,
  input logic              bus_err_n_i,
  input logic              ack0_n_i,
  input logic              ack1_n_i,
  input logic              tmo_expired_i,
  input logic              bus_wr_try_i,
  input logic              slave_only_i,
  input logic              master_en_o
);
  logic quiet;
  assign quiet = bus_err_n_i & ~tmo_expired_i & ~(bus_wr_try_i & ~rdata_o[B_RDONLY]);

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cs_i && we_i |=> rdata_o[10:0] == $past(wdata_i[10:0]));
  a_r3_status_untouched_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    cs_i && we_i && quiet |=> $stable(rdata_o[15:11]));
  a_r4_read_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    cs_i && !we_i && quiet |=> rdata_o[15:11] == 5'h1f);
  a_r5_wrerr_in_rdonly: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_try_i && !rdata_o[B_RDONLY] |=> !rdata_o[11]);
  a_r6_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_expired_i |=> !rdata_o[12]);
  a_r7_err_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_err_n_i |=> !rdata_o[15] && rdata_o[14:13] == $past({ack1_n_i, ack0_n_i}));
  a_r9_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    slave_only_i |-> !master_en_o);
endmodule

bind bicsr_top bicsr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .we_i(we_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .bus_err_n_i(bus_err_n_i), .ack0_n_i(ack0_n_i),
  .ack1_n_i(ack1_n_i), .tmo_expired_i(tmo_expired_i),
  .bus_wr_try_i(bus_wr_try_i), .slave_only_i(slave_only_i),
  .master_en_o(master_en_o)
);

// File: tb/bicsr_top_test.sv
`timescale 1ns/1ps
module bicsr_top_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [10:0] strap = '0;
  logic cs = 0, we = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic err_n = 1, a0 = 1, a1 = 1, tmo = 0, bwr = 0, slv = 0;
  logic sysctl, blk, narrow, bounce, rdonly, men, toff, fair;
  logic [1:0] tsel;

  int vecs = 0, fails = 0;
  logic [10:0] exp_c;
  logic [4:0]  exp_s;
  bit done = 0;

  always #2.5 clk = ~clk;

  bicsr_top uut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .cs_i(cs), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .bus_err_n_i(err_n), .ack0_n_i(a0),
    .ack1_n_i(a1), .tmo_expired_i(tmo), .bus_wr_try_i(bwr),
    .slave_only_i(slv), .sysctl_en_o(sysctl), .blk_xfer_o(blk),
    .narrow_cpu_o(narrow), .bounce_en_o(bounce), .rd_only_o(rdonly),
    .master_en_o(men), .tmo_sel_o(tsel), .tmo_off_o(toff), .fair_en_o(fair)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] next_stat(logic [4:0] s, logic [10:0] c);
    logic [4:0] n;
    n = (cs && !we) ? 5'h1f : s;
    if (bwr && !c[5]) n[0] = 1'b0;
    if (tmo) n[1] = 1'b0;
    if (!err_n) begin n[4] = 1'b0; n[2] = a0; n[3] = a1; end
    return n;
  endfunction

  task automatic check_outputs();
    chk("R2 rdata", {16'h0, rdata}, {16'h0, exp_s, exp_c});
    chk("R9 master_en", {31'h0, men}, {31'h0, !exp_c[6] && !slv});
    chk("R10 decode", {23'h0, sysctl, blk, narrow, bounce, rdonly, fair, tsel, toff},
        {23'h0, !exp_c[0], !exp_c[2], !exp_c[3], exp_c[4], !exp_c[5], !exp_c[10],
         exp_c[9:8], exp_c[9] & exp_c[8]});
  endtask

  // apply current inputs for one edge and update the model
  task automatic step(string req);
    logic [10:0] c0;
    @(posedge clk);
    c0 = exp_c;
    exp_s = next_stat(exp_s, c0);
    if (cs && we) exp_c = wdata[10:0];
    #1;
    check_outputs();
    chk(req, {16'h0, rdata}, {16'h0, exp_s, exp_c});
  endtask

  task automatic idle();
    cs = 0; we = 0; err_n = 1; tmo = 0; bwr = 0;
  endtask

  task automatic do_reset(logic [10:0] s);
    rst_n = 0; strap = s; idle();
    repeat (3) @(posedge clk);
    #1;
    exp_c = s; exp_s = 5'h1f;
    chk("R1 reset load", {16'h0, rdata}, {16'h0, 5'h1f, s});
    rst_n = 1;
    strap = ~s;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset(11'h5a5);
    check_outputs();
    // R2 write, R3 high bits ignored
    cs = 1; we = 1; wdata = 16'hf800 | 16'h0040; step("R3 write high bits");
    chk("R3 status kept", {27'h0, rdata[15:11]}, 32'h1f);
    wdata = 16'h0000; step("R2 write zero");
    idle();
    // R5 read-only: bit5=0 now -> write attempt clears bit11
    bwr = 1; step("R5 wrerr in read-only");
    chk("R5 bit11", {31'h0, rdata[11]}, 32'h0);
    idle(); cs = 1; we = 0; step("R4 read sets");
    chk("R4 all ones", {27'h0, rdata[15:11]}, 32'h1f);
    idle(); cs = 1; we = 1; wdata = 16'h0020; step("R2 leave read-only");
    idle(); bwr = 1; step("R5 no wrerr when bit5=1");
    chk("R5 bit11 stays", {31'h0, rdata[11]}, 32'h1);
    // R6 timeout
    idle(); tmo = 1; step("R6 timeout");
    chk("R6 bit12", {31'h0, rdata[12]}, 32'h0);
    // R7 error capture with ack levels
    idle(); err_n = 0; a0 = 0; a1 = 1; step("R7 capture");
    chk("R7 bits15..13", {29'h0, rdata[15:13]}, {29'h0, 3'b010});
    idle(); a0 = 1; a1 = 0; step("R7 ack ignored without error");
    chk("R7 ack held", {30'h0, rdata[14:13]}, {30'h0, 2'b10});
    // R8 read and error same edge
    cs = 1; we = 0; err_n = 0; a0 = 1; a1 = 1; tmo = 0; step("R8 read vs error");
    chk("R8 error wins", {27'h0, rdata[15:11]}, {27'h0, 5'b01111});
    idle();
    // R9 slave-only gate
    cs = 1; we = 1; wdata = 16'h0000; step("R9 enable master");
    idle(); slv = 1; #1; chk("R9 slave gate", {31'h0, men}, 32'h0);
    slv = 0; #1; chk("R9 master on", {31'h0, men}, 32'h1);
    // R10 timer encodings
    for (int k = 0; k < 4; k++) begin
      cs = 1; we = 1; wdata = 16'(k) << 8; step("R10 timer select");
      idle(); #1; chk("R10 tmo_off", {31'h0, toff}, {31'h0, k == 3});
    end
    // random mix
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = $urandom;
      cs = r[0]; we = r[1]; wdata = r[31:16];
      err_n = (r[4:2] != 0); a0 = r[5]; a1 = r[6];
      tmo = (r[9:7] == 0); bwr = r[10]; slv = (r[13:11] == 0);
      step("R8 random mix");
    end
    idle();
    // R1 second reset with a different pattern
    do_reset(11'h3c2);
    check_outputs();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule